// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits in the decode stage of a two-wide in-order pipeline. Each cycle it is given the two instructions just decoded, older first. It decides whether both may go on together into the two parallel execution pipes, or whether only the older one goes. The decision is finished within the decode stage. It is latched at the boundary into the register-read stage, so the issue strobes are valid there one cycle later.

The younger instruction is refused a place beside the older one for any of these reasons:
- it reads a register that the older one writes;
- both instructions write the same register;
- either instruction needs both pipes at once;
- its class is not one that the second pipe can execute. A parameter mask lists the classes the second pipe accepts.

When pairing is refused, a hold output goes high in the same cycle. The front end then presents the younger instruction again, this time in the older slot, beside the next fetched instruction.

The hold output is also raised when the older slot is empty and the younger slot holds an instruction. In that cycle nothing issues from the younger slot, so program order is kept.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, issueOld and issueYoung are 0.
- R2: issueOld and issueYoung are registered. They show the decision for the pair presented in the previous cycle and change only at a rising clock edge. holdYoung is combinational and shows the decision for the current pair.
- R3: issueOld is 1 in the cycle after oldValid was 1, and 0 after oldValid was 0.
- R4: The pair is refused when oldDstEn is 1, oldDst is nonzero, and either youngSrcA or youngSrcB equals oldDst.
- R5: The pair is refused when oldDstEn and youngDstEn are both 1 and oldDst equals youngDst (nonzero).
- R6: Register number 0 never causes a refusal: it is ignored as a destination for both the read-after-write check and the same-destination check.
- R7: The pair is refused when oldBoth or youngBoth is 1.
- R8: A younger instruction of class c (youngClass = c) may pair only if bit c of SECOND_PIPE_MASK is 1. The default mask is 8'h27, which allows classes 0, 1, 2 and 5.
- R9: When oldValid is 0, neither instruction issues, and holdYoung equals youngValid.
- R10: When oldValid is 1, holdYoung is 1 exactly when youngValid is 1 and the pair is refused. When youngValid is 0, holdYoung is 0 and issueYoung is 0.
- R11: When both slots are valid and no rule in R4, R5, R7 or R8 applies, holdYoung is 0 and issueYoung is 1 in the next cycle.
- R12: issueYoung is never 1 unless issueOld is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oldValid | input | 1 | Older slot holds an instruction |
| oldDst | input | REG_W | Older destination register |
| oldDstEn | input | 1 | Older instruction writes oldDst |
| oldBoth | input | 1 | Older instruction needs both pipes |
| youngValid | input | 1 | Younger slot holds an instruction |
| youngClass | input | CLS_W | Younger opcode class |
| youngDst | input | REG_W | Younger destination register |
| youngDstEn | input | 1 | Younger instruction writes youngDst |
| youngSrcA | input | REG_W | Younger first source register |
| youngSrcB | input | REG_W | Younger second source register |
| youngBoth | input | 1 | Younger instruction needs both pipes |
| issueOld | output | 1 | Older instruction issues to the first pipe (register-read stage) |
| issueYoung | output | 1 | Younger instruction issues to the second pipe (register-read stage) |
| holdYoung | output | 1 | Younger instruction must be presented again in the older slot |

## Verification
Several refusal reasons can be present in the same cycle: a read-after-write hit together with a same-destination hit, or a both-pipe flag on a younger instruction whose class the second pipe does not accept. In every such case the outputs must still give exactly one outcome, pair or hold, and never both. The bench provokes these overlaps with an exhaustive sweep over every register combination of a 3-bit register file, followed by a sweep over every class, both-pipe flag and valid combination. It judges each vector against a refusal predicate that it computes itself. It also checks that the registered issue strobes do not change until the clock edge after the pair was presented, while the hold output already reflects the new pair.

// File: rtl/dip_pkg.sv
package dip_pkg;

  // Conditions computed by the datapath and consumed by the control
  typedef struct packed {
    logic olderValid;
    logic youngerValid;
    logic rawHit;
    logic wawHit;
    logic olderBoth;
    logic youngerBoth;
    logic classOk;
  } pair_cond_t;

  // Strobes from control back to the datapath / edge of the block
  typedef struct packed {
    logic issueOlder;
    logic pairBoth;
    logic holdYounger;
  } issue_strobe_t;

endpackage

// File: rtl/dip_datapath.sv
module dip_datapath
  import dip_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned CLS_W   = 3,
  parameter int unsigned NUM_SRC = 2,
  parameter logic [(2**CLS_W)-1:0] SECOND_PIPE_MASK = 'h27
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  oldValid,
  input  logic [REG_W-1:0]      oldDst,
  input  logic                  oldDstEn,
  input  logic                  oldBoth,
  input  logic                  youngValid,
  input  logic [CLS_W-1:0]      youngClass,
  input  logic [REG_W-1:0]      youngDst,
  input  logic                  youngDstEn,
  input  logic [REG_W-1:0]      youngSrc [NUM_SRC],
  input  logic                  youngBoth,
  input  issue_strobe_t         strobe,
  output pair_cond_t            cond,
  output logic                  issueOldQ,
  output logic                  issueYoungQ
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] srcHit;
  logic               oldDstLive;
  logic               youngDstLive;

  // Register 0 is a sink: writing it creates no dependence
  assign oldDstLive   = oldDstEn && (oldDst != ZERO_REG);
  assign youngDstLive = youngDstEn && (youngDst != ZERO_REG);

  // One comparator per younger source operand
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_cmp
    assign srcHit[s] = (youngSrc[s] == oldDst);
  end

  always_comb begin
    cond              = '0;
    cond.olderValid   = oldValid;
    cond.youngerValid = youngValid;
    cond.rawHit       = oldDstLive && (|srcHit);
    cond.wawHit       = oldDstLive && youngDstLive && (youngDst == oldDst);
    cond.olderBoth    = oldBoth;
    cond.youngerBoth  = youngBoth;
    cond.classOk      = SECOND_PIPE_MASK[youngClass];
  end

  // Decode / register-read boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issueOldQ   <= 1'b0;
      issueYoungQ <= 1'b0;
    end else begin
      issueOldQ   <= strobe.issueOlder;
      issueYoungQ <= strobe.pairBoth;
    end
  end

  // R6: a zero older destination never flags a hazard
  a_r6_zero_reg_neutral: assert property (@(posedge clk) disable iff (!rst_n)
    (oldDst == ZERO_REG) |-> (!cond.rawHit && !cond.wawHit));

  // R2: registered strobes follow the previous decision
  a_r2_issue_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (issueYoungQ == $past(strobe.pairBoth)) && (issueOldQ == $past(strobe.issueOlder)));

  // R12: younger never issues alone
  a_r12_young_needs_old: assert property (@(posedge clk) disable iff (!rst_n)
    issueYoungQ |-> issueOldQ);

endmodule

// File: rtl/dip_control.sv
module dip_control
  import dip_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  pair_cond_t    cond,
  output issue_strobe_t strobe
);

  logic bothSlots;
  logic dataClear;
  logic resourceClear;
  logic pairOk;

  assign bothSlots     = cond.olderValid && cond.youngerValid;
  assign dataClear     = !cond.rawHit && !cond.wawHit;
  assign resourceClear = !cond.olderBoth && !cond.youngerBoth && cond.classOk;
  assign pairOk        = bothSlots && dataClear && resourceClear;

  always_comb begin
    strobe             = '0;
    strobe.issueOlder  = cond.olderValid;
    strobe.pairBoth    = pairOk;
    strobe.holdYounger = cond.youngerValid && !pairOk;
  end

  a_r4_raw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cond.rawHit |-> !strobe.pairBoth);

  a_r5_waw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cond.wawHit |-> !strobe.pairBoth);

  a_r7_both_pipe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cond.olderBoth || cond.youngerBoth) |-> !strobe.pairBoth);

  a_r8_class_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !cond.classOk |-> !strobe.pairBoth);

  a_r9_empty_older: assert property (@(posedge clk) disable iff (!rst_n)
    !cond.olderValid |-> (!strobe.issueOlder && !strobe.pairBoth
                          && (strobe.holdYounger == cond.youngerValid)));

  a_r10_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.holdYounger && strobe.pairBoth));

endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dip_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned CLS_W = 3,
  parameter logic [(2**CLS_W)-1:0] SECOND_PIPE_MASK = 'h27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oldValid,
  input  logic [REG_W-1:0] oldDst,
  input  logic             oldDstEn,
  input  logic             oldBoth,
  input  logic             youngValid,
  input  logic [CLS_W-1:0] youngClass,
  input  logic [REG_W-1:0] youngDst,
  input  logic             youngDstEn,
  input  logic [REG_W-1:0] youngSrcA,
  input  logic [REG_W-1:0] youngSrcB,
  input  logic             youngBoth,
  output logic             issueOld,
  output logic             issueYoung,
  output logic             holdYoung
);

  localparam int unsigned NUM_SRC = 2;

  pair_cond_t    cond;
  issue_strobe_t strobe;
  logic [REG_W-1:0] youngSrc [NUM_SRC];

  assign youngSrc[0] = youngSrcA;
  assign youngSrc[1] = youngSrcB;

  dip_datapath #(
    .REG_W           (REG_W),
    .CLS_W           (CLS_W),
    .NUM_SRC         (NUM_SRC),
    .SECOND_PIPE_MASK(SECOND_PIPE_MASK)
  ) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .oldValid   (oldValid),
    .oldDst     (oldDst),
    .oldDstEn   (oldDstEn),
    .oldBoth    (oldBoth),
    .youngValid (youngValid),
    .youngClass (youngClass),
    .youngDst   (youngDst),
    .youngDstEn (youngDstEn),
    .youngSrc   (youngSrc),
    .youngBoth  (youngBoth),
    .strobe     (strobe),
    .cond       (cond),
    .issueOldQ  (issueOld),
    .issueYoungQ(issueYoung)
  );

  dip_control u_control (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (cond),
    .strobe(strobe)
  );

  assign holdYoung = strobe.holdYounger;

endmodule

// File: tb/dual_issue_pair_check_bench.sv
module dual_issue_pair_check_bench;

  localparam int REG_W = 3;
  localparam int CLS_W = 3;
  localparam logic [7:0] MASK = 8'h27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oldValid = 0, oldDstEn = 0, oldBoth = 0;
  logic youngValid = 0, youngDstEn = 0, youngBoth = 0;
  logic [REG_W-1:0] oldDst = '0, youngDst = '0, youngSrcA = '0, youngSrcB = '0;
  logic [CLS_W-1:0] youngClass = '0;
  logic issueOld, issueYoung, holdYoung;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic prevOld = 0, prevYoung = 0;

  always #2 clk = ~clk;

  dual_issue_pair_check #(.REG_W(REG_W), .CLS_W(CLS_W), .SECOND_PIPE_MASK(MASK)) u_dual_issue_pair_check (
    .clk(clk), .rst_n(rst_n),
    .oldValid(oldValid), .oldDst(oldDst), .oldDstEn(oldDstEn), .oldBoth(oldBoth),
    .youngValid(youngValid), .youngClass(youngClass), .youngDst(youngDst),
    .youngDstEn(youngDstEn), .youngSrcA(youngSrcA), .youngSrcB(youngSrcB),
    .youngBoth(youngBoth),
    .issueOld(issueOld), .issueYoung(issueYoung), .holdYoung(holdYoung)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic expPair();
    logic raw, waw;
    raw = oldDstEn && (oldDst != 0) && ((youngSrcA == oldDst) || (youngSrcB == oldDst));
    waw = oldDstEn && youngDstEn && (oldDst == youngDst) && (oldDst != 0);
    return oldValid && youngValid && !raw && !waw && !oldBoth && !youngBoth && MASK[youngClass];
  endfunction

  // Apply current inputs: check comb hold, stability of registered outputs, then next-cycle issue
  task automatic applyVec(input string holdTag);
    logic p, h;
    p = expPair();
    h = youngValid && !p;
    #1;
    chk(holdTag, holdYoung, h);
    chk("R2 stable before edge", issueYoung, prevYoung);
    @(posedge clk);
    @(negedge clk);
    chk("R3 issueOld", issueOld, oldValid);
    chk("R12 issueYoung", issueYoung, p);
    prevOld = oldValid;
    prevYoung = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset issueOld", issueOld, 1'b0);
    chk("R1 reset issueYoung", issueYoung, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset issueOld", issueOld, 1'b0);
    chk("R1 after reset issueYoung", issueYoung, 1'b0);

    // Dependence sweep: every register combination
    oldValid = 1; youngValid = 1; youngClass = 0; oldBoth = 0; youngBoth = 0;
    for (int od = 0; od < 8; od++)
      for (int oe = 0; oe < 2; oe++)
        for (int ya = 0; ya < 8; ya++)
          for (int yb = 0; yb < 8; yb++)
            for (int yd = 0; yd < 8; yd++)
              for (int ye = 0; ye < 2; ye++) begin
                oldDst = od[2:0]; oldDstEn = oe[0];
                youngSrcA = ya[2:0]; youngSrcB = yb[2:0];
                youngDst = yd[2:0]; youngDstEn = ye[0];
                if (oe == 1 && od != 0 && (ya == od || yb == od)) applyVec("R4 raw hold");
                else if (oe == 1 && ye == 1 && od != 0 && od == yd) applyVec("R5 waw hold");
                else if (od == 0) applyVec("R6 zero reg hold");
                else applyVec("R11 clear pair hold");
              end

    // Class / both-pipe / valid sweep with independent registers
    oldDst = 1; oldDstEn = 1; youngSrcA = 2; youngSrcB = 3; youngDst = 4; youngDstEn = 1;
    for (int c = 0; c < 8; c++)
      for (int ob = 0; ob < 2; ob++)
        for (int yb = 0; yb < 2; yb++)
          for (int ov = 0; ov < 2; ov++)
            for (int yv = 0; yv < 2; yv++) begin
              youngClass = c[2:0]; oldBoth = ob[0]; youngBoth = yb[0];
              oldValid = ov[0]; youngValid = yv[0];
              if (ov == 0) applyVec("R9 empty older hold");
              else if (yv == 0) applyVec("R10 empty younger hold");
              else if (ob == 1 || yb == 1) applyVec("R7 both-pipe hold");
              else if (!MASK[c]) applyVec("R8 class hold");
              else applyVec("R11 class pair hold");
            end

    // Overlap: RAW and WAW together plus both-pipe and disallowed class
    oldValid = 1; youngValid = 1; oldDst = 5; oldDstEn = 1; youngSrcA = 5;
    youngDst = 5; youngDstEn = 1; youngBoth = 1; youngClass = 3; oldBoth = 0;
    applyVec("R10 overlap hold");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule